// File: doc/BRIEF.md
# Shared-Address Transmit/Receive FIFO Port

This block sits behind a serial host interface whose shift register has already assembled whole bytes. The first byte after chip select falls is a header. Its top bit is the read/write flag and the next bit is the burst flag. Its low six bits are an address. One address, 0x3F, reaches two 64-byte queues. A write header leads to the transmit queue, which the host can only fill. A read header leads to the receive queue, which the host can only drain. Every byte the host sends gets exactly one reply byte back, so the host can see queue levels while it streams data.

On the radio side, the transmit queue is drained by a pop strobe and the receive queue is filled by a push strobe. The radio controller supplies its current state code. It also supplies flush requests for each queue. A flush request is obeyed only in three states. Both queues are emptied when the radio moves into its sleep state.

The access state machine has six states. ACC_HDR waits for a header. ACC_TX_ONE and ACC_TX_STREAM accept transmit data. ACC_RX_ONE and ACC_RX_STREAM return receive data. ACC_SKIP discards bytes of an access aimed at another address. Its transitions are as follows:
- ACC_HDR moves to one of the four data states on a header addressed to 0x3F, and to ACC_SKIP on any other header.
- Each single-byte data state returns to ACC_HDR after one data byte.
- The streaming states and ACC_SKIP hold until chip select rises.
- A high chip select forces ACC_HDR from every state.

Top module: `spi_fifo_port`

## Requirements
- R1: A header byte is decoded as read/write = bit 7, burst = bit 6 and address = bits 5:0. Only address 0x3F enters a queue state. Any other header enters ACC_SKIP: the following bytes change no queue until chip select rises, and each of them gets the reply 0x00.
- R2: Every byte strobed while chip select is low produces reply_valid exactly one cycle later. No reply_valid appears otherwise.
- R3: The reply to a header is the status byte {1'b0, radio_state[2:0], count[3:0]}. The count is the transmit free space when bit 7 of the header is 0, and the receive fill level when bit 7 is 1. The count saturates at 15.
- R4: The reply to each transmit data byte is the status byte carrying the free space from before that byte is stored. The last byte that fits gets the count 1. A byte sent to a full queue gets the count 0.
- R5: Header 0x3F or 0xBF takes exactly one data byte, and the next byte is treated as a header. Header 0x7F or 0xFF keeps taking data bytes until chip select goes high. A high chip select returns the machine to ACC_HDR.
- R6: The transmit queue holds 64 bytes. tx_data shows the oldest byte, tx_empty flags an empty queue, and each tx_pop removes one byte in write order. A pop on an empty queue is ignored.
- R7: A host write to a full transmit queue is dropped and sets tx_ovf. tx_ovf stays set until the transmit queue is flushed.
- R8: The receive queue holds 64 bytes and fills from rx_push. Each receive data byte replies with the oldest byte and removes it. A push into a full queue is dropped, and rx_full reports a full queue.
- R9: A receive data byte sent while the receive queue is empty replies with the last byte that was removed (0x00 after reset) and sets rx_unf. rx_unf stays set until the receive queue is flushed.
- R10: A flush request for either queue is obeyed only when radio_state is IDLE (0), TX_UNDERFLOW (4) or RX_OVERFLOW (5). An obeyed flush empties that queue and clears its flag. In any other state the request has no effect.
- R11: When radio_state changes into SLEEP (1) from any other value, both queues are emptied and both flags are cleared.
- R12: After reset, both queues are empty and both flags are clear. reply_valid is low and the machine is in ACC_HDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| byte_valid | input | 1 | One-cycle strobe for a host byte |
| byte_in | input | 8 | Host byte (header or data) |
| reply_valid | output | 1 | Reply byte valid, one cycle after the strobe |
| reply_byte | output | 8 | Status byte or receive data |
| radio_state | input | 3 | Radio state code (0 IDLE, 1 SLEEP, 4 TX_UNDERFLOW, 5 RX_OVERFLOW) |
| tx_flush_req | input | 1 | Transmit queue flush request |
| rx_flush_req | input | 1 | Receive queue flush request |
| tx_pop | input | 1 | Radio removes the oldest transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | Radio stores a receive byte |
| rx_data | input | 8 | Receive byte to store |
| rx_full | output | 1 | Receive queue full |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| rx_unf | output | 1 | Sticky receive underflow flag |

## Verification
A reply byte comes out one register stage after its strobe. The bench therefore drives each strobe on a falling edge and reads the reply on the next falling edge. Queue contents, the empty and full outputs, and both flags change on the same rising edge that accepts a byte, pop, push or flush, so they are compared half a period later. The behavioural queue model updates on every rising edge from the inputs the bench holds stable there, and each falling edge compares every output with it. Directed checks add fixed expected bytes for saturation, the final fitting byte, the flush-gating states and sleep entry.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    typedef enum logic [2:0] {
        ACC_HDR,
        ACC_TX_ONE,
        ACC_TX_STREAM,
        ACC_RX_ONE,
        ACC_RX_STREAM,
        ACC_SKIP
    } acc_state_e;

    localparam logic [2:0] RADIO_IDLE     = 3'd0;
    localparam logic [2:0] RADIO_SLEEP    = 3'd1;
    localparam logic [2:0] RADIO_TX_UNDER = 3'd4;
    localparam logic [2:0] RADIO_RX_OVER  = 3'd5;

    localparam logic [5:0] QUEUE_ADDR = 6'h3F;

    function automatic logic [3:0] sat15(input logic [15:0] v);
        return (v > 16'd15) ? 4'd15 : v[3:0];
    endfunction

    function automatic logic [7:0] status_byte(input logic [2:0] st, input logic [15:0] cnt);
        return {1'b0, st, sat15(cnt)};
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rp];
    assign count   = cnt;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    p_full_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> full);

endmodule

// File: rtl/spi_fifo_access.sv
module spi_fifo_access
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          byte_valid,
    input  logic [7:0]    byte_in,
    input  logic [2:0]    radio_state,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic [7:0]    rx_head,
    input  logic          rx_empty,
    input  logic          rx_flush,
    output logic          tx_wr,
    output logic [7:0]    tx_wdata,
    output logic          rx_rd,
    output logic          reply_valid,
    output logic [7:0]    reply_byte
);

    acc_state_e    state_q, state_d;
    logic [7:0]    reply_d;
    logic [7:0]    last_rx;
    logic [CW-1:0] tx_free;
    logic          take;

    assign take     = byte_valid && !cs_n;
    assign tx_free  = CW'(DEPTH) - tx_count;
    assign tx_wdata = byte_in;

    always_comb begin
        state_d = state_q;
        tx_wr   = 1'b0;
        rx_rd   = 1'b0;
        reply_d = 8'h00;
        if (cs_n) begin
            state_d = ACC_HDR;
        end else if (byte_valid) begin
            unique case (state_q)
                ACC_HDR: begin
                    reply_d = byte_in[7] ? status_byte(radio_state, 16'(rx_count))
                                         : status_byte(radio_state, 16'(tx_free));
                    if (byte_in[5:0] == QUEUE_ADDR) begin
                        unique case (byte_in[7:6])
                            2'b00:   state_d = ACC_TX_ONE;
                            2'b01:   state_d = ACC_TX_STREAM;
                            2'b10:   state_d = ACC_RX_ONE;
                            default: state_d = ACC_RX_STREAM;
                        endcase
                    end else begin
                        state_d = ACC_SKIP;
                    end
                end
                ACC_TX_ONE, ACC_TX_STREAM: begin
                    tx_wr   = 1'b1;
                    reply_d = status_byte(radio_state, 16'(tx_free));
                    if (state_q == ACC_TX_ONE) state_d = ACC_HDR;
                end
                ACC_RX_ONE, ACC_RX_STREAM: begin
                    rx_rd   = 1'b1;
                    reply_d = rx_empty ? last_rx : rx_head;
                    if (state_q == ACC_RX_ONE) state_d = ACC_HDR;
                end
                ACC_SKIP: reply_d = 8'h00;
                default:  state_d = ACC_HDR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_HDR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reply_valid <= 1'b0;
            reply_byte  <= 8'h00;
            last_rx     <= 8'h00;
        end else begin
            reply_valid <= take;
            if (take) reply_byte <= reply_d;
            if (rx_rd && !rx_empty && !rx_flush) last_rx <= rx_head;
        end
    end

    p_reply_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> reply_valid);

    p_no_spurious_reply_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !reply_valid);

    p_cs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state_q == ACC_HDR));

    p_single_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (state_q == ACC_TX_ONE || state_q == ACC_RX_ONE)) |=> (state_q == ACC_HDR));

    p_skip_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACC_SKIP) |-> (!tx_wr && !rx_rd));

endmodule

// File: rtl/spi_fifo_port.sv
module spi_fifo_port
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    output logic       reply_valid,
    output logic [7:0] reply_byte,
    input  logic [2:0] radio_state,
    input  logic       tx_flush_req,
    input  logic       rx_flush_req,
    input  logic       tx_pop,
    output logic [7:0] tx_data,
    output logic       tx_empty,
    input  logic       rx_push,
    input  logic [7:0] rx_data,
    output logic       rx_full,
    output logic       tx_ovf,
    output logic       rx_unf
);

    logic [2:0]    prev_state;
    logic          sleep_entry, flush_ok, tx_flush, rx_flush;
    logic          tx_wr, rx_rd, tx_full, rx_empty;
    logic [7:0]    tx_wdata, rx_head;
    logic [CW-1:0] tx_count, rx_count;

    assign sleep_entry = (radio_state == RADIO_SLEEP) && (prev_state != RADIO_SLEEP);
    assign flush_ok    = (radio_state == RADIO_IDLE) || (radio_state == RADIO_TX_UNDER)
                      || (radio_state == RADIO_RX_OVER);
    assign tx_flush    = (tx_flush_req && flush_ok) || sleep_entry;
    assign rx_flush    = (rx_flush_req && flush_ok) || sleep_entry;

    spi_fifo_access #(.DEPTH(DEPTH)) u_access (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .radio_state(radio_state), .tx_count(tx_count), .rx_count(rx_count),
        .rx_head(rx_head), .rx_empty(rx_empty), .rx_flush(rx_flush),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
        .reply_valid(reply_valid), .reply_byte(reply_byte)
    );

    byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_wr), .push_data(tx_wdata),
        .pop(tx_pop), .head(tx_data), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .push_data(rx_data),
        .pop(rx_rd), .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_state <= RADIO_IDLE;
            tx_ovf     <= 1'b0;
            rx_unf     <= 1'b0;
        end else begin
            prev_state <= radio_state;
            if (tx_flush)              tx_ovf <= 1'b0;
            else if (tx_wr && tx_full) tx_ovf <= 1'b1;
            if (rx_flush)               rx_unf <= 1'b0;
            else if (rx_rd && rx_empty) rx_unf <= 1'b1;
        end
    end

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf && !tx_flush) |=> tx_ovf);

    p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_unf && !rx_flush) |=> rx_unf);

    p_sleep_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_entry |=> (tx_empty && rx_empty && !tx_ovf && !rx_unf));

    p_flush_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush_req && !flush_ok && !sleep_entry && !tx_empty && !tx_pop) |=> !tx_empty);

endmodule

// File: tb/spi_fifo_port_tb.sv
module spi_fifo_port_tb_top;

    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       reply_valid;
    logic [7:0] reply_byte;
    logic [2:0] radio_state = 3'd0;
    logic       tx_flush_req = 1'b0, rx_flush_req = 1'b0, tx_pop = 1'b0, rx_push = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [7:0] tx_data;
    logic       tx_empty, rx_full, tx_ovf, rx_unf;

    always #4 clk = ~clk;

    spi_fifo_port #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .reply_valid(reply_valid), .reply_byte(reply_byte), .radio_state(radio_state),
        .tx_flush_req(tx_flush_req), .rx_flush_req(rx_flush_req), .tx_pop(tx_pop),
        .tx_data(tx_data), .tx_empty(tx_empty), .rx_push(rx_push), .rx_data(rx_data),
        .rx_full(rx_full), .tx_ovf(tx_ovf), .rx_unf(rx_unf)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] last_reply;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0] txq[$], rxq[$];
    int         m_st;
    logic [7:0] m_last;
    bit         m_ovf, m_unf, e_rv;
    logic [7:0] e_rb;
    logic [2:0] m_prev;
    string      e_tag;

    function automatic logic [7:0] stat(input logic [2:0] st, input int c);
        return {1'b0, st, (c > 15) ? 4'd15 : 4'(c)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_st = 0; m_last = 8'h00; m_ovf = 0; m_unf = 0; m_prev = 3'd0; e_rv = 0; e_rb = 8'h00;
            e_tag = "R12";
        end else begin
            automatic bit sl = (radio_state == 3'd1) && (m_prev != 3'd1);
            automatic bit ok = (radio_state == 3'd0) || (radio_state == 3'd4) || (radio_state == 3'd5);
            automatic bit ftx = (tx_flush_req && ok) || sl;
            automatic bit frx = (rx_flush_req && ok) || sl;
            automatic int tn = txq.size();
            automatic int rn = rxq.size();
            automatic bit wr = 0, rd = 0;
            automatic logic [7:0] head = (rn > 0) ? rxq[0] : 8'h00;
            e_rv = 0;
            if (cs_n) m_st = 0;
            else if (byte_valid) begin
                e_rv = 1;
                case (m_st)
                    0: begin
                        e_rb = byte_in[7] ? stat(radio_state, rn) : stat(radio_state, DEPTH - tn);
                        e_tag = "R3";
                        if (byte_in[5:0] == 6'h3F) m_st = 1 + {byte_in[7], byte_in[6]};
                        else m_st = 5;
                    end
                    1, 2: begin
                        wr = 1; e_rb = stat(radio_state, DEPTH - tn); e_tag = "R4";
                        if (m_st == 1) m_st = 0;
                    end
                    3, 4: begin
                        rd = 1; e_rb = (rn > 0) ? head : m_last; e_tag = (rn > 0) ? "R8" : "R9";
                        if (m_st == 3) m_st = 0;
                    end
                    default: begin e_rb = 8'h00; e_tag = "R1"; end
                endcase
            end
            if (ftx) begin txq.delete(); m_ovf = 0; end
            else begin
                if (wr && tn >= DEPTH) m_ovf = 1;
                if (tx_pop && tn > 0) void'(txq.pop_front());
                if (wr && tn < DEPTH) txq.push_back(byte_in);
            end
            if (frx) begin rxq.delete(); m_unf = 0; end
            else begin
                if (rd && rn == 0) m_unf = 1;
                if (rd && rn > 0) begin m_last = head; void'(rxq.pop_front()); end
                if (rx_push && rn < DEPTH) rxq.push_back(rx_data);
            end
            m_prev = radio_state;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(reply_valid == e_rv, "R2 reply_valid", reply_valid, e_rv);
            if (e_rv) check(reply_byte == e_rb, e_tag, reply_byte, e_rb);
            check(tx_ovf == m_ovf, "R7 tx_ovf", tx_ovf, m_ovf);
            check(rx_unf == m_unf, "R9 rx_unf", rx_unf, m_unf);
            check(tx_empty == (txq.size() == 0), "R6 tx_empty", tx_empty, txq.size() == 0);
            if (txq.size() > 0) check(tx_data == txq[0], "R6 tx_data", tx_data, txq[0]);
            check(rx_full == (rxq.size() == DEPTH), "R8 rx_full", rx_full, rxq.size() == DEPTH);
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk); byte_valid = 1'b1; byte_in = b;
        @(negedge clk); byte_valid = 1'b0; last_reply = reply_byte;
    endtask
    task automatic cs_lo(); @(negedge clk); cs_n = 1'b0; endtask
    task automatic cs_hi(); @(negedge clk); cs_n = 1'b1; endtask
    task automatic pulse_pop(); @(negedge clk); tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0; endtask
    task automatic push_rx(input logic [7:0] d);
        @(negedge clk); rx_push = 1'b1; rx_data = d; @(negedge clk); rx_push = 1'b0;
    endtask
    task automatic flush(input bit tx);
        @(negedge clk);
        if (tx) tx_flush_req = 1'b1; else rx_flush_req = 1'b1;
        @(negedge clk); tx_flush_req = 1'b0; rx_flush_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(tx_empty && !rx_full && !tx_ovf && !rx_unf && !reply_valid, "R12 reset", 
              {tx_empty, rx_full, tx_ovf, rx_unf, reply_valid}, 5'b10000);

        // R5 two single writes back to back without raising chip select
        cs_lo();
        send(8'h3F); check(last_reply == 8'h0F, "R3 saturated free", last_reply, 8'h0F);
        send(8'hAA);
        send(8'h3F); send(8'hBB);
        cs_hi();
        @(negedge clk);
        check(tx_data == 8'hAA, "R5 first single", tx_data, 8'hAA);
        pulse_pop();
        check(tx_data == 8'hBB, "R6 order", tx_data, 8'hBB);
        pulse_pop();
        check(tx_empty, "R5 exactly two bytes", tx_empty, 1'b1);

        // R4 / R7 fill by burst
        cs_lo();
        send(8'h7F);
        for (int i = 0; i < DEPTH; i++) send(8'(i + 1));
        check(last_reply == 8'h01, "R4 last fitting", last_reply, 8'h01);
        send(8'hEE);
        check(last_reply == 8'h00, "R4 full", last_reply, 8'h00);
        cs_hi();
        @(negedge clk);
        check(tx_ovf, "R7 overflow set", tx_ovf, 1'b1);

        // R10 gated transmit flush
        radio_state = 3'd2;
        flush(1'b1);
        check(!tx_empty && tx_ovf, "R10 ignored in RX", {tx_empty, tx_ovf}, 2'b01);
        radio_state = 3'd0;
        flush(1'b1);
        check(tx_empty && !tx_ovf, "R10 honoured in IDLE", {tx_empty, tx_ovf}, 2'b10);

        // R8 / R9 receive path
        for (int i = 0; i < 5; i++) push_rx(8'h10 + 8'(i));
        cs_lo();
        send(8'hBF); check(last_reply == 8'h05, "R3 rx avail", last_reply, 8'h05);
        send(8'h00); check(last_reply == 8'h10, "R8 single read", last_reply, 8'h10);
        send(8'hFF);
        for (int i = 0; i < 4; i++) send(8'h00);
        check(last_reply == 8'h14, "R8 burst last", last_reply, 8'h14);
        send(8'h00); check(last_reply == 8'h14, "R9 empty repeats", last_reply, 8'h14);
        cs_hi();
        @(negedge clk);
        check(rx_unf, "R9 underflow set", rx_unf, 1'b1);

        // R10 gated receive flush
        radio_state = 3'd3;
        flush(1'b0);
        check(rx_unf, "R10 ignored in TX", rx_unf, 1'b1);
        radio_state = 3'd5;
        flush(1'b0);
        check(!rx_unf, "R10 honoured in RX_OVERFLOW", rx_unf, 1'b0);
        cs_lo(); send(8'hBF); cs_hi();
        check(last_reply == 8'h50, "R3 state field", last_reply, 8'h50);

        // R11 sleep entry
        radio_state = 3'd0;
        for (int i = 0; i < 3; i++) push_rx(8'h30 + 8'(i));
        cs_lo(); send(8'h7F); send(8'h41); send(8'h42); cs_hi();
        radio_state = 3'd1;
        repeat (2) @(negedge clk);
        check(tx_empty, "R11 tx emptied", tx_empty, 1'b1);
        cs_lo(); send(8'hBF); cs_hi();
        check(last_reply == 8'h10, "R11 rx emptied", last_reply, 8'h10);
        radio_state = 3'd0;

        // R1 other address ignored
        cs_lo();
        send(8'h05); send(8'h77); send(8'h3F);
        check(last_reply == 8'h00, "R1 skip reply", last_reply, 8'h00);
        cs_hi();
        @(negedge clk);
        check(tx_empty, "R1 no write", tx_empty, 1'b1);

        // R8 receive queue full, extra push dropped
        for (int i = 0; i <= DEPTH; i++) push_rx(8'(i + 8'h80));
        check(rx_full, "R8 full", rx_full, 1'b1);
        cs_lo(); send(8'hBF); send(8'h00); cs_hi();
        check(last_reply == 8'h80, "R8 oldest", last_reply, 8'h80);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule